// File: doc/BRIEF.md
# Dual-Buffer Ethernet Transmit Controller

This block is the transmit half of a small Ethernet MAC. A host reaches it through a 32-bit register bus that moves whole words only. There are two transmit buffers of `BUF_BYTES` bytes each, used in ping-pong fashion. The host fills a buffer with frame bytes, writes that buffer's length word, and then writes its control word. The control word either sends the frame or loads the station address from the first six bytes of the buffer.

A send streams the buffer out one byte per clock on a byte-wide valid/data/last interface, starting at the lowest byte address. The frame never stalls once it has started. A frame always runs to its end before another frame or command is taken up. Preamble, FCS and the PHY side belong to the stages downstream.

When a command finishes, its busy bits drop. If interrupts are enabled both for that buffer and globally, a one-cycle interrupt pulse follows. The one global enable sits only in buffer 0's register set.

Top module: `ethtx_dualbuf`

## Requirements
- R1: After reset, every control, length and global-enable register reads 0, `station_mac` is 0, and `tx_valid` and `irq` are low.
- R2: Byte address bit 11 selects the buffer (base 0x000 or 0x800). Inside a buffer, word offsets 0x7F4 (length, 11 bits, read zero-extended) and 0x7FC (control) are registers. Offset 0x7F8 is the global enable only in buffer 0; every other word is frame storage that reads back as written.
- R3: Writing control with bits[1:0]=01 sends the buffer's length in bytes, one per cycle with `tx_valid` high, from buffer byte 0 upward. Byte 4k+j is taken from bits [8j+7:8j] of word k, and `tx_last` is high only on the final byte.
- R4: Writing control with bits[1:0]=11 sends nothing and loads `station_mac`: bits [31:0] from buffer word 0 and bits [47:32] from bits [15:0] of word 1, so byte 0 lands at bits [7:0].
- R5: While a command is pending or running, control reads back exactly as written. Once it completes, bits[1:0] read 0 and all other bits keep their written values. A control write with bit 0 clear starts nothing and is stored with bits[1:0] cleared.
- R6: A control write to a buffer whose bit 0 is still set is ignored entirely. It changes neither the register nor the running command.
- R7: On completion, `irq` pulses high for exactly one cycle. This happens only when bit 3 of that buffer's control word and bit 31 of the global enable are both set. The global enable stores only bit 31.
- R8: Frames are never interleaved. Once `tx_valid` rises it stays high every cycle until `tx_last`, and a second buffer's frame follows only after the first one's last byte.
- R9: A send with length 0 puts no byte out, yet it completes with the normal bit clearing and interrupt rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_we | input | 1 | Word write strobe |
| host_addr | input | 12 | Byte address; bits [1:0] are ignored |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for `host_addr`, combinational |
| tx_valid | output | 1 | A frame byte is present |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| irq | output | 1 | One-cycle completion interrupt |
| station_mac | output | 48 | Station address, byte 0 at bits [7:0] |

## Verification
A corrupted byte counter or a wrong buffer select shows up on the very first streamed bytes, as wrong data or a misplaced `tx_last` within the frame. A stuck engine state shows up as control bit 0 that never drops, which the bench sees on its next poll of control. A lost busy check or a wrong interrupt gate shows up within one frame time: as an extra or missing `irq` pulse, a changed `station_mac`, or a control readback that differs from the value written.

// File: rtl/ethtx_pkg.sv
package ethtx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_PROG, ST_DONE} eng_state_e;
  localparam int CTRL_GO   = 0;
  localparam int CTRL_PROG = 1;
  localparam int CTRL_IEN  = 3;
  localparam int GIE_BIT   = 31;
endpackage

// File: rtl/ethtx_bufmem.sv
module ethtx_bufmem #(
  parameter int WORDS = 512,
  parameter int WA_W  = 9
) (
  input  logic            clk,
  input  logic            we,
  input  logic            wbuf,
  input  logic [WA_W-1:0] waddr,
  input  logic [31:0]     wdata,
  input  logic            ra_buf,
  input  logic [WA_W-1:0] ra_addr,
  output logic [31:0]     ra_data,
  input  logic            rb_buf,
  input  logic [WA_W-1:0] rb_addr,
  output logic [31:0]     rb_data
);
  logic [1:0][31:0] a_word;
  logic [1:0][31:0] b_word;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [31:0] store [WORDS];
    logic        bank_en;
    assign bank_en = we && (wbuf == 1'(b));
    always_ff @(posedge clk) begin
      if (bank_en) store[waddr] <= wdata;
    end
    assign a_word[b] = store[ra_addr];
    assign b_word[b] = store[rb_addr];
  end

  assign ra_data = a_word[ra_buf];
  assign rb_data = b_word[rb_buf];
endmodule

// File: rtl/ethtx_regs.sv
module ethtx_regs
  import ethtx_pkg::*;
#(
  parameter int WA_W  = 9,
  parameter int LEN_W = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_buf,
  input  logic [WA_W-1:0]       wr_word,
  input  logic [31:0]           wr_data,
  input  logic                  done,
  input  logic                  done_buf,
  output logic [1:0][31:0]      ctrl,
  output logic [1:0][LEN_W-1:0] len,
  output logic                  gie,
  output logic                  irq
);
  localparam logic [WA_W-1:0] W_LEN  = WA_W'((1 << WA_W) - 3);
  localparam logic [WA_W-1:0] W_GIE  = WA_W'((1 << WA_W) - 2);
  localparam logic [WA_W-1:0] W_CTRL = WA_W'((1 << WA_W) - 1);

  logic [1:0][31:0]      ctrl_q, ctrl_d;
  logic [1:0][LEN_W-1:0] len_q, len_d;
  logic                  gie_q, gie_d, irq_q, irq_d;

  always_comb begin
    ctrl_d = ctrl_q;
    len_d  = len_q;
    gie_d  = gie_q;
    irq_d  = 1'b0;
    for (int b = 0; b < 2; b++) begin
      if (done && done_buf == 1'(b)) ctrl_d[b][1:0] = 2'b00;
      if (wr_en && wr_buf == 1'(b)) begin
        if (wr_word == W_CTRL && !ctrl_q[b][CTRL_GO])
          ctrl_d[b] = wr_data[CTRL_GO] ? wr_data : (wr_data & ~32'h3);
        if (wr_word == W_LEN) len_d[b] = wr_data[LEN_W-1:0];
      end
    end
    if (wr_en && !wr_buf && wr_word == W_GIE) gie_d = wr_data[GIE_BIT];
    if (done) irq_d = ctrl_q[done_buf][CTRL_IEN] && gie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      len_q  <= '0;
      gie_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      len_q  <= len_d;
      gie_q  <= gie_d;
      irq_q  <= irq_d;
    end
  end

  assign ctrl = ctrl_q;
  assign len  = len_q;
  assign gie  = gie_q;
  assign irq  = irq_q;
endmodule

// File: rtl/ethtx_engine.sv
module ethtx_engine
  import ethtx_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            busy,
  input  logic [1:0]            prog,
  input  logic [1:0][LEN_W-1:0] len,
  output logic                  sel,
  output logic [LEN_W-1:0]      byte_idx,
  output logic                  tx_valid,
  output logic                  tx_last,
  output logic                  done,
  output logic [1:0]            mac_we
);
  eng_state_e       state_q, state_d;
  logic             sel_q, sel_d, pick;
  logic [LEN_W-1:0] cnt_q, cnt_d, len_q, len_d;

  assign pick = ~busy[0];

  always_comb begin
    state_d  = state_q;
    sel_d    = sel_q;
    cnt_d    = cnt_q;
    len_d    = len_q;
    tx_valid = 1'b0;
    tx_last  = 1'b0;
    done     = 1'b0;
    mac_we   = 2'b00;
    case (state_q)
      ST_IDLE: begin
        if (|busy) begin
          sel_d = pick;
          cnt_d = '0;
          len_d = len[pick];
          if (prog[pick])            state_d = ST_PROG;
          else if (len[pick] == '0)  state_d = ST_DONE;
          else                       state_d = ST_SEND;
        end
      end
      ST_SEND: begin
        tx_valid = 1'b1;
        tx_last  = (cnt_q == len_q - LEN_W'(1));
        cnt_d    = cnt_q + LEN_W'(1);
        if (tx_last) state_d = ST_DONE;
      end
      ST_PROG: begin
        mac_we = cnt_q[2] ? 2'b10 : 2'b01;
        cnt_d  = cnt_q + LEN_W'(4);
        if (cnt_q[2]) state_d = ST_DONE;
      end
      ST_DONE: begin
        done    = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= 1'b0;
      cnt_q   <= '0;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
    end
  end

  assign sel      = sel_q;
  assign byte_idx = cnt_q;
endmodule

// File: rtl/ethtx_dualbuf.sv
module ethtx_dualbuf
  import ethtx_pkg::*;
#(
  parameter int BUF_BYTES = 2048
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            host_we,
  input  logic [$clog2(BUF_BYTES):0]      host_addr,
  input  logic [31:0]                     host_wdata,
  output logic [31:0]                     host_rdata,
  output logic                            tx_valid,
  output logic [7:0]                      tx_data,
  output logic                            tx_last,
  output logic                            irq,
  output logic [47:0]                     station_mac
);
  localparam int ADDR_W = $clog2(BUF_BYTES) + 1;
  localparam int WORDS  = BUF_BYTES / 4;
  localparam int WA_W   = $clog2(WORDS);
  localparam int LEN_W  = $clog2(BUF_BYTES);
  localparam logic [WA_W-1:0] W_LEN  = WA_W'(WORDS - 3);
  localparam logic [WA_W-1:0] W_GIE  = WA_W'(WORDS - 2);
  localparam logic [WA_W-1:0] W_CTRL = WA_W'(WORDS - 1);

  logic [1:0] rst_sync_q;
  logic       rst_n_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_q = rst_sync_q[1];

  logic            h_buf, h_reg, mem_we;
  logic [WA_W-1:0] h_word;
  assign h_buf  = host_addr[ADDR_W-1];
  assign h_word = host_addr[ADDR_W-2:2];
  assign h_reg  = (h_word == W_LEN) || (h_word == W_CTRL) || (h_word == W_GIE && !h_buf);
  assign mem_we = host_we && !h_reg;

  logic [1:0][31:0]      ctrl_v;
  logic [1:0][LEN_W-1:0] len_v;
  logic                  gie_en, eng_done, eng_sel;
  logic [LEN_W-1:0]      eng_byte;
  logic [1:0]            mac_we;
  logic [31:0]           host_word, eng_word;

  ethtx_bufmem #(.WORDS(WORDS), .WA_W(WA_W)) u_mem (
    .clk(clk), .we(mem_we), .wbuf(h_buf), .waddr(h_word), .wdata(host_wdata),
    .ra_buf(h_buf), .ra_addr(h_word), .ra_data(host_word),
    .rb_buf(eng_sel), .rb_addr(eng_byte[LEN_W-1:2]), .rb_data(eng_word)
  );

  ethtx_regs #(.WA_W(WA_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n_q), .wr_en(host_we), .wr_buf(h_buf), .wr_word(h_word),
    .wr_data(host_wdata), .done(eng_done), .done_buf(eng_sel),
    .ctrl(ctrl_v), .len(len_v), .gie(gie_en), .irq(irq)
  );

  ethtx_engine #(.LEN_W(LEN_W)) u_eng (
    .clk(clk), .rst_n(rst_n_q),
    .busy({ctrl_v[1][CTRL_GO], ctrl_v[0][CTRL_GO]}),
    .prog({ctrl_v[1][CTRL_PROG], ctrl_v[0][CTRL_PROG]}),
    .len(len_v), .sel(eng_sel), .byte_idx(eng_byte),
    .tx_valid(tx_valid), .tx_last(tx_last), .done(eng_done), .mac_we(mac_we)
  );

  assign tx_data = 8'(eng_word >> {eng_byte[1:0], 3'b000});

  logic [47:0] mac_q;
  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      mac_q <= '0;
    end else begin
      if (mac_we[0]) mac_q[31:0]  <= eng_word;
      if (mac_we[1]) mac_q[47:32] <= eng_word[15:0];
    end
  end
  assign station_mac = mac_q;

  always_comb begin
    if (h_word == W_CTRL)               host_rdata = ctrl_v[h_buf];
    else if (h_word == W_LEN)           host_rdata = 32'(len_v[h_buf]);
    else if (h_word == W_GIE && !h_buf) host_rdata = {gie_en, 31'b0};
    else                                host_rdata = host_word;
  end
endmodule

// File: rtl/ethtx_chk.sv
module ethtx_chk (
  input logic        clk,
  input logic        rst_n_q,
  input logic        tx_valid,
  input logic        tx_last,
  input logic        irq,
  input logic        gie_en,
  input logic        eng_done,
  input logic        eng_sel,
  input logic        ctrl_wr0,
  input logic [31:0] ctrl0,
  input logic [31:0] ctrl1
);
  AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n_q)
    tx_last |-> tx_valid); // R3
  AST_DONE_CLEARS_CMD: assert property (@(posedge clk) disable iff (!rst_n_q)
    (eng_done && !eng_sel) |=> (ctrl0[1:0] == 2'b00)); // R5
  AST_DONE_CLEARS_CMD1: assert property (@(posedge clk) disable iff (!rst_n_q)
    (eng_done && eng_sel) |=> (ctrl1[1:0] == 2'b00)); // R5
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n_q)
    (ctrl_wr0 && ctrl0[0] && !(eng_done && !eng_sel)) |=> $stable(ctrl0)); // R6
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n_q)
    irq |=> !irq); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n_q)
    (irq && !$past(eng_done)) |-> 1'b0); // R7
  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n_q)
    $rose(irq) |-> $past(gie_en)); // R7
  AST_FRAME_CONTIG: assert property (@(posedge clk) disable iff (!rst_n_q)
    (tx_valid && !tx_last) |=> tx_valid); // R8
endmodule

bind ethtx_dualbuf ethtx_chk u_chk (
  .clk(clk), .rst_n_q(rst_n_q), .tx_valid(tx_valid), .tx_last(tx_last), .irq(irq),
  .gie_en(gie_en), .eng_done(eng_done), .eng_sel(eng_sel),
  .ctrl_wr0(host_we && !h_buf && h_word == W_CTRL),
  .ctrl0(ctrl_v[0]), .ctrl1(ctrl_v[1])
);

// File: tb/ethtx_dualbuf_tb.sv
module ethtx_dualbuf_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, host_we, tx_valid, tx_last, irq;
  logic [11:0] host_addr;
  logic [31:0] host_wdata, host_rdata;
  logic [7:0]  tx_data;
  logic [47:0] station_mac;

  ethtx_dualbuf u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .irq(irq), .station_mac(station_mac)
  );

  int n_tests = 0, n_fail = 0;
  logic [7:0] cap [1024];
  bit         capl [1024];
  int cap_n = 0, irq_n = 0;
  logic irq_prev = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_valid && cap_n < 1024) begin
        cap[cap_n]  = tx_data;
        capl[cap_n] = tx_last;
        cap_n++;
      end
      if (irq) irq_n++;
      if (irq && irq_prev) chk(1'b0, "R7 irq wider than one cycle", 2, 1);
      irq_prev = irq;
    end
  end

  function automatic logic [7:0] pat(int b, int i, int L);
    return 8'((i * 7 + b * 50 + L * 3 + 1) & 255);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v0, v1;
    int t = 0;
    do begin
      rd(12'h7FC, v0); rd(12'hFFC, v1); t++;
    end while ((v0[0] || v1[0]) && t < 5000);
    repeat (3) @(negedge clk);
    if (t >= 5000) chk(1'b0, "R5 command never completed", t, 0);
  endtask

  task automatic fill(input int b, input int L, input int plen);
    for (int w = 0; w < (L + 3) / 4; w++)
      wr(12'(b * 2048 + w * 4), {pat(b, 4*w+3, plen), pat(b, 4*w+2, plen),
                                 pat(b, 4*w+1, plen), pat(b, 4*w, plen)});
  endtask

  task automatic send_check(input int b, input int L);
    logic [31:0] v;
    fill(b, L, L);
    wr(12'(b * 2048 + 12'h7F4), 32'(L));
    cap_n = 0;
    wr(12'(b * 2048 + 12'h7FC), 32'h1);
    wait_idle();
    chk(cap_n == L, (L == 0) ? "R9 zero-length byte count" : "R3 byte count", cap_n, L);
    for (int i = 0; i < L && i < cap_n; i++) begin
      chk(cap[i] == pat(b, i, L), "R3 byte value", cap[i], pat(b, i, L));
      chk(capl[i] == (i == L - 1), "R3 last marker", capl[i], (i == L - 1));
    end
    rd(12'(b * 2048 + 12'h7FC), v);
    chk(v == 0, "R5 control after send", v, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [47:0] m;
    rst_n = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(12'h7FC, v); chk(v == 0, "R1 ctrl0 reset", v, 0);
    rd(12'hFFC, v); chk(v == 0, "R1 ctrl1 reset", v, 0);
    rd(12'h7F4, v); chk(v == 0, "R1 len0 reset", v, 0);
    rd(12'h7F8, v); chk(v == 0, "R1 gie reset", v, 0);
    chk(!tx_valid && !irq, "R1 outputs idle", {tx_valid, irq}, 0);
    chk(station_mac == 0, "R1 mac reset", station_mac, 0);

    // R2 map
    wr(12'h014, 32'hA5A5_1234); rd(12'h014, v); chk(v == 32'hA5A5_1234, "R2 buf0 data", v, 32'hA5A5_1234);
    wr(12'hFF8, 32'h1357_9BDF); rd(12'hFF8, v); chk(v == 32'h1357_9BDF, "R2 buf1 word at gie slot", v, 32'h1357_9BDF);
    rd(12'h7F8, v); chk(v == 0, "R7 gie untouched by buf1", v, 0);
    wr(12'h7F8, 32'h8000_0001); rd(12'h7F8, v); chk(v == 32'h8000_0000, "R7 gie keeps bit31 only", v, 32'h8000_0000);
    wr(12'hFF4, 32'hFFFF_F805); rd(12'hFF4, v); chk(v == 32'h005, "R2 len 11-bit", v, 32'h005);
    wr(12'h7F8, 32'h0);

    // R3 sweep over lengths and both buffers
    for (int b = 0; b < 2; b++) begin
      for (int L = 1; L <= 12; L++) send_check(b, L);
      send_check(b, 61);
      send_check(b, 200);
    end
    // R9
    send_check(0, 0);
    send_check(1, 0);

    // R7 gating sweep on buffer 1
    for (int g = 0; g < 2; g++) begin
      for (int ie = 0; ie < 2; ie++) begin
        wr(12'h7F8, {g[0], 31'b0});
        fill(1, 3, 3);
        wr(12'hFF4, 32'd3);
        irq_n = 0;
        wr(12'hFFC, {28'b0, ie[0], 3'b001});
        wait_idle();
        chk(irq_n == (g & ie), "R7 irq gating", irq_n, g & ie);
        rd(12'hFFC, v);
        chk(v == {28'b0, ie[0], 3'b000}, "R5 other bits kept", v, {28'b0, ie[0], 3'b000});
      end
    end

    // R5 busy readback, R6 busy write ignored
    wr(12'h7F8, 32'h8000_0000);
    fill(0, 40, 40);
    wr(12'h7F4, 32'd40);
    cap_n = 0; irq_n = 0;
    wr(12'h7FC, 32'h9);
    rd(12'h7FC, v); chk(v == 32'h9, "R5 busy readback", v, 32'h9);
    wr(12'h7FC, 32'h3);
    rd(12'h7FC, v); chk(v == 32'h9, "R6 busy write dropped", v, 32'h9);
    wait_idle();
    chk(cap_n == 40, "R6 frame length intact", cap_n, 40);
    chk(station_mac == 0, "R6 no program ran", station_mac, 0);
    chk(irq_n == 1, "R7 one irq", irq_n, 1);
    rd(12'h7FC, v); chk(v == 32'h8, "R5 done readback", v, 32'h8);

    // R4 program from buffer 0 (no irq: bit3 clear), then buffer 1 (irq)
    wr(12'h000, 32'h4433_2211); wr(12'h004, 32'hCCBB_6655);
    cap_n = 0; irq_n = 0;
    wr(12'h7FC, 32'h3);
    wait_idle();
    chk(station_mac == 48'h6655_4433_2211, "R4 mac from buf0", station_mac, 48'h6655_4433_2211);
    chk(cap_n == 0, "R4 no bytes sent", cap_n, 0);
    chk(irq_n == 0, "R7 no irq without bit3", irq_n, 0);
    rd(12'h7FC, v); chk(v == 0, "R5 ctrl after program", v, 0);
    wr(12'h800, 32'hDEAD_BEEF); wr(12'h804, 32'h0000_0A0B);
    wr(12'hFFC, 32'hB);
    wait_idle();
    chk(station_mac == 48'h0A0B_DEAD_BEEF, "R4 mac from buf1", station_mac, 48'h0A0B_DEAD_BEEF);
    chk(irq_n == 1, "R7 irq on program", irq_n, 1);

    // R5 no-op control values
    m = station_mac; cap_n = 0;
    wr(12'h7FC, 32'h2);
    repeat (6) @(negedge clk);
    rd(12'h7FC, v); chk(v == 0, "R5 prog bit alone stored clear", v, 0);
    chk(station_mac == m && cap_n == 0, "R5 no action on 10", cap_n, 0);
    wr(12'h7FC, 32'hF0);
    rd(12'h7FC, v); chk(v == 32'hF0, "R5 plain bits kept", v, 32'hF0);

    // R8 two back-to-back frames
    wr(12'h7F8, 32'h0);
    fill(0, 20, 20); fill(1, 15, 15);
    wr(12'h7F4, 32'd20); wr(12'hFF4, 32'd15);
    cap_n = 0;
    wr(12'h7FC, 32'h1);
    wr(12'hFFC, 32'h1);
    wait_idle();
    chk(cap_n == 35, "R8 total bytes", cap_n, 35);
    for (int i = 0; i < 35 && i < cap_n; i++) begin
      logic [7:0] e;
      e = (i < 20) ? pat(0, i, 20) : pat(1, i - 20, 15);
      chk(cap[i] == e, "R8 byte order", cap[i], e);
      chk(capl[i] == (i == 19 || i == 34), "R8 last positions", capl[i], (i == 19 || i == 34));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule